// File: doc/BRIEF.md
# Serial-Access Control Register Bank

This block holds the 16-bit control words of a larger device and makes them reachable through a four-wire serial port. A host shifts in frames of a direction bit, a 7-bit register address and one or more 16-bit data words. When a frame carries more than one data word, each further word goes to another address, which register 0 selects: the next address up, the next address down, or the same address again. The serial pins are brought into the system clock domain through synchronizers, and all register updates happen in that domain.

The map is sparse. Only 29 offsets hold storage: 0 to 20, 22, 23, 30, 31, 32, 34, 35 and 79. Every other offset is reserved. Each register has a staged copy and a live copy. A staging mode lets the host load many registers whose new values reach the live outputs together on the next write to register 0. That write can also request a calibration start, or restore every register to its power-up value.

Top module: `spi_regbank`

## Requirements
- R1: After reset, every register's live value equals {8'hC2 ^ {1'b0,addr}, 8'h30 ^ {1'b0,addr}}, where addr is its 7-bit offset.
- R2: A frame is sent MSB first while chip select is low, and MOSI is sampled on rising SCLK. Bit 23 is the direction (1 = read, 0 = write), bits 22:16 are the address and bits 15:0 are the data. A single write to a valid offset updates that register.
- R3: In a read frame, MISO carries the addressed register MSB first during the 16 data bit periods. It changes after falling SCLK, so the host samples it on rising SCLK.
- R4: With register 0 bit 10 = 1 and bit 11 = 0, each further data word in a frame applies to the address plus one.
- R5: With register 0 bits 10 and 11 both 0, each further word applies to the address minus one, and the address wraps from 0 to 127.
- R6: With register 0 bit 11 = 1, the address stays the same for every word, whatever bit 10 holds. The block-access mode is taken from the live register 0 when the address byte completes.
- R7: A write to a reserved offset changes no register, and a read from a reserved offset returns zero.
- R8: While register 16 bit 8 is set in the live copy, a write to any offset other than 0 changes only the staged copy. The next write to register 0 copies every staged value to the live outputs.
- R9: Live register 1 bit 13 selects what is read back: 0 returns the staged (written) value, 1 returns the live value.
- R10: A write to register 0 with bit 1 set restores every staged and live register to its R1 value, so bit 1 of register 0 reads back as 0.
- R11: A write to register 0 with bit 2 set gives exactly one system-clock cycle of `cal_start`. Other writes give none.
- R12: MISO is low whenever chip select has been high for a full synchronized cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| reg_live | output | 464 | Live register values, 16 bits per register in ascending offset order |
| cal_start | output | 1 | One-cycle calibration request |

## Verification
A table of single-word writes followed by read-backs covers valid offsets at both ends of the map and in the sparse tail, as well as reserved offsets inside and outside the dense range. This shows that a real store is distinct from a silently dropped write. Multi-word frames are then run in each addressing mode: ascending, descending with a wrap through 0 into reserved space, and hold with the direction bit also set. Each of these leaves a different set of registers changed, so any wrong step direction or priority shows. Staged writes are read back before and after the commit under both read-back selections, which separates the staged copy from the live copy. Calibration and soft-reset writes close the run.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int DW    = 16;
  localparam int AW    = 7;
  localparam int NREG  = 29;
  localparam int IW    = $clog2(NREG);
  localparam int HDRW  = AW + 1;
  localparam int B_SRST  = 1;
  localparam int B_CAL   = 2;
  localparam int B_ASC   = 10;
  localparam int B_HOLD  = 11;
  localparam int B_DBUF  = 8;
  localparam int B_RBSEL = 13;
  localparam int I_RB    = 1;
  localparam int I_DBUF  = 16;
  localparam int DENSE_TOP = 20;

  function automatic logic addr_ok(input logic [AW-1:0] a);
    if (int'(a) <= DENSE_TOP) return 1'b1;
    case (a)
      7'd22, 7'd23, 7'd30, 7'd31, 7'd32, 7'd34, 7'd35, 7'd79: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [IW-1:0] addr_idx(input logic [AW-1:0] a);
    if (int'(a) <= DENSE_TOP) return IW'(a);
    case (a)
      7'd22: return IW'(21);
      7'd23: return IW'(22);
      7'd30: return IW'(23);
      7'd31: return IW'(24);
      7'd32: return IW'(25);
      7'd34: return IW'(26);
      7'd35: return IW'(27);
      7'd79: return IW'(28);
      default: return '0;
    endcase
  endfunction

  function automatic logic [AW-1:0] idx_addr(input int i);
    if (i <= DENSE_TOP) return AW'(i);
    case (i)
      21: return 7'd22;
      22: return 7'd23;
      23: return 7'd30;
      24: return 7'd31;
      25: return 7'd32;
      26: return 7'd34;
      27: return 7'd35;
      default: return 7'd79;
    endcase
  endfunction

  function automatic logic [DW-1:0] dflt_val(input int i);
    logic [7:0] a8;
    a8 = {1'b0, idx_addr(i)};
    return {8'hC2 ^ a8, 8'h30 ^ a8};
  endfunction

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a,
                                              input logic hold, input logic asc);
    if (hold) return a;
    return asc ? a + 1'b1 : a - 1'b1;
  endfunction
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame
  import spi_rb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_s,
  input  logic          cs_n_s,
  input  logic          mosi_s,
  input  logic          hold_i,
  input  logic          asc_i,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          miso,
  output logic          wr_ev,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic          sclk_q;
  logic          rise, fall;
  logic [AW-1:0] hdr_sr;
  logic [2:0]    hcnt;
  logic          in_data, rw, hold_l, asc_l;
  logic [AW-1:0] cur_addr, nxt;
  logic [DW-2:0] dsr;
  logic [3:0]    dcnt;
  logic [DW-1:0] osr;
  logic [AW-1:0] hdr_addr;

  assign rise     = sclk_s & ~sclk_q;
  assign fall     = ~sclk_s & sclk_q;
  assign hdr_addr = {hdr_sr[AW-2:0], mosi_s};
  assign nxt      = next_addr(cur_addr, hold_l, asc_l);
  assign rd_addr  = in_data ? nxt : hdr_addr;
  assign miso     = osr[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; hdr_sr <= '0; hcnt <= '0; in_data <= 1'b0; rw <= 1'b0;
      hold_l <= 1'b0; asc_l <= 1'b0; cur_addr <= '0; dsr <= '0; dcnt <= '0;
      osr <= '0; wr_ev <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      sclk_q <= sclk_s;
      wr_ev  <= 1'b0;
      if (cs_n_s) begin
        hcnt <= '0; in_data <= 1'b0; dcnt <= '0; osr <= '0;
      end else if (rise) begin
        if (!in_data) begin
          hdr_sr <= hdr_addr;
          hcnt   <= hcnt + 1'b1;
          if (hcnt == 3'd7) begin
            in_data  <= 1'b1;
            rw       <= hdr_sr[AW-1];
            cur_addr <= hdr_addr;
            hold_l   <= hold_i;
            asc_l    <= asc_i;
            osr      <= hdr_sr[AW-1] ? rd_data : '0;
          end
        end else begin
          dsr  <= {dsr[DW-3:0], mosi_s};
          dcnt <= dcnt + 1'b1;
          if (dcnt == 4'd15) begin
            wr_ev    <= ~rw;
            wr_addr  <= cur_addr;
            wr_data  <= {dsr, mosi_s};
            cur_addr <= nxt;
            osr      <= rw ? rd_data : '0;
          end
        end
      end else if (fall && in_data && dcnt != 4'd0) begin
        osr <= {osr[DW-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_rb_store.sv
module spi_rb_store
  import spi_rb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ev,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [AW-1:0]      rd_addr,
  output logic [DW-1:0]      rd_data,
  output logic [NREG*DW-1:0] live_flat,
  output logic               hold_o,
  output logic               asc_o,
  output logic               dbuf_o,
  output logic               cal_o
);
  logic [DW-1:0] stg [NREG];
  logic [DW-1:0] liv [NREG];
  logic          wr_ok, wr_r0, srst, rb_live;
  logic [IW-1:0] wr_idx, rd_idx;

  assign wr_ok   = wr_ev && addr_ok(wr_addr);
  assign wr_r0   = wr_ok && (wr_addr == '0);
  assign srst    = wr_r0 && wr_data[B_SRST];
  assign wr_idx  = addr_idx(wr_addr);
  assign rd_idx  = addr_idx(rd_addr);
  assign rb_live = liv[I_RB][B_RBSEL];
  assign hold_o  = liv[0][B_HOLD];
  assign asc_o   = liv[0][B_ASC];
  assign dbuf_o  = liv[I_DBUF][B_DBUF];

  always_comb begin
    if (!addr_ok(rd_addr)) rd_data = '0;
    else if (rb_live)      rd_data = liv[rd_idx];
    else                   rd_data = stg[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        stg[i] <= dflt_val(i);
        liv[i] <= dflt_val(i);
      end
      cal_o <= 1'b0;
    end else begin
      cal_o <= wr_r0 && wr_data[B_CAL];
      if (srst) begin
        for (int i = 0; i < NREG; i++) begin
          stg[i] <= dflt_val(i);
          liv[i] <= dflt_val(i);
        end
      end else if (wr_r0) begin
        for (int i = 1; i < NREG; i++) liv[i] <= stg[i];
        liv[0] <= wr_data;
        stg[0] <= wr_data;
      end else if (wr_ok) begin
        stg[wr_idx] <= wr_data;
        if (!dbuf_o) liv[wr_idx] <= wr_data;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign live_flat[g*DW +: DW] = liv[g];
  end
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
  import spi_rb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_sclk,
  input  logic               spi_cs_n,
  input  logic               spi_mosi,
  output logic               spi_miso,
  output logic [NREG*DW-1:0] reg_live,
  output logic               cal_start
);
  logic [2:0]    pins_s;
  logic          sclk_s, cs_n_s, mosi_s;
  logic          wr_ev;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;
  logic          hold_m, asc_m, dbuf_on;

  spi_rb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sclk, spi_cs_n, spi_mosi}), .q(pins_s)
  );
  assign {sclk_s, cs_n_s, mosi_s} = pins_s;

  spi_rb_frame u_frame (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
    .hold_i(hold_m), .asc_i(asc_m), .rd_data(rd_data), .rd_addr(rd_addr),
    .miso(spi_miso), .wr_ev(wr_ev), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  spi_rb_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_ev(wr_ev), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .live_flat(reg_live),
    .hold_o(hold_m), .asc_o(asc_m), .dbuf_o(dbuf_on), .cal_o(cal_start)
  );
endmodule

// File: rtl/spi_regbank_chk.sv
module spi_regbank_chk
  import spi_rb_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_ev,
  input logic [AW-1:0]      wr_addr,
  input logic [DW-1:0]      wr_data,
  input logic               dbuf_on,
  input logic               cal_start,
  input logic [NREG*DW-1:0] live_flat,
  input logic               cs_n_s,
  input logic               miso
);
  logic [NREG*DW-1:0] dflt_flat;
  for (genvar g = 0; g < NREG; g++) begin : g_dflt
    assign dflt_flat[g*DW +: DW] = dflt_val(g);
  end

  // R11
  cal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && wr_addr == '0 && wr_data[B_CAL]) |=> cal_start);
  // R11
  cal_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start);
  // R10
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && wr_addr == '0 && wr_data[B_SRST]) |=> (live_flat == dflt_flat));
  // R7
  reserved_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && !addr_ok(wr_addr)) |=> $stable(live_flat));
  // R8
  staged_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && dbuf_on && wr_addr != '0) |=> $stable(live_flat));
  // R12
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> !miso);
endmodule

bind spi_regbank spi_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ev(wr_ev), .wr_addr(wr_addr), .wr_data(wr_data),
  .dbuf_on(dbuf_on), .cal_start(cal_start), .live_flat(reg_live),
  .cs_n_s(cs_n_s), .miso(spi_miso)
);

// File: tb/sim_spi_regbank.sv
`timescale 1ns/1ps
module sim_spi_regbank;
  localparam int HALF = 8;
  localparam int NR = 29;
  localparam logic [6:0] ADDRS [NR] = '{7'd0, 7'd1, 7'd2, 7'd3, 7'd4, 7'd5, 7'd6, 7'd7,
    7'd8, 7'd9, 7'd10, 7'd11, 7'd12, 7'd13, 7'd14, 7'd15, 7'd16, 7'd17, 7'd18, 7'd19,
    7'd20, 7'd22, 7'd23, 7'd30, 7'd31, 7'd32, 7'd34, 7'd35, 7'd79};
  // {addr, write data, expected read}
  localparam logic [38:0] VEC [6] = '{
    {7'd3,  16'h1234, 16'h1234},
    {7'd20, 16'hABCD, 16'hABCD},
    {7'd79, 16'h0F0F, 16'h0F0F},
    {7'd21, 16'hFFFF, 16'h0000},
    {7'd40, 16'h5555, 16'h0000},
    {7'd35, 16'h8001, 16'h8001}};

  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0;
  logic miso, cal_start;
  logic [NR*16-1:0] live;
  logic [15:0] tx [4];
  logic [15:0] rx [4];
  int checks = 0, fails = 0, cal_hi = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_regbank u0 (.clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .reg_live(live), .cal_start(cal_start));

  always @(posedge clk) if (cal_start) cal_hi++;

  function automatic logic [15:0] dflt(input logic [6:0] a);
    return {8'hC2 ^ {1'b0, a}, 8'h30 ^ {1'b0, a}};
  endfunction

  function automatic logic [15:0] lv(input logic [6:0] a);
    for (int i = 0; i < NR; i++) if (ADDRS[i] == a) return live[i*16 +: 16];
    return 16'hxxxx;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bitx(input logic d, output logic q);
    mosi = d;
    repeat (HALF) @(negedge clk);
    sclk = 1; q = miso;
    repeat (HALF) @(negedge clk);
    sclk = 0;
  endtask

  task automatic spi(input logic rd, input logic [6:0] a, input int n);
    logic [7:0] h;
    logic b;
    h = {rd, a};
    @(negedge clk); cs_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 7; i >= 0; i--) bitx(h[i], b);
    for (int w = 0; w < n; w++)
      for (int i = 15; i >= 0; i--) begin bitx(tx[w][i], b); rx[w][i] = b; end
    repeat (HALF) @(negedge clk); cs_n = 1;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic wr1(input logic [6:0] a, input logic [15:0] d);
    tx[0] = d; spi(1'b0, a, 1);
  endtask

  task automatic rd1(input logic [6:0] a, output logic [15:0] d);
    tx[0] = '0; spi(1'b1, a, 1); d = rx[0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL R2 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [NR*16-1:0] snap;
    int c0, ok;
    repeat (5) @(negedge clk); rst_n = 1;
    repeat (5) @(negedge clk);

    // R1: all defaults after reset
    ok = 1;
    for (int i = 0; i < NR; i++) if (live[i*16 +: 16] !== dflt(ADDRS[i])) ok = 0;
    chk("R1 all defaults", 16'(ok), 16'd1);
    chk("R12 miso idle", {15'd0, miso}, 16'd0);
    rd1(7'd5, r); chk("R3 read default", r, dflt(7'd5));

    // R2 R3 R7: table of single writes and reads
    for (int v = 0; v < 6; v++) begin
      logic [6:0] a; logic [15:0] d, e;
      {a, d, e} = VEC[v];
      snap = live;
      wr1(a, d);
      rd1(a, r);
      chk("R2/R3 table read", r, e);
      if (e == 16'h0000) chk("R7 reserved ignored", 16'(live == snap), 16'd1);
      else chk("R2 live update", lv(a), d);
    end
    chk("R12 miso idle after read", {15'd0, miso}, 16'd0);

    // R4 ascending block
    wr1(7'd0, 16'h0400);
    tx[0] = 16'h0011; tx[1] = 16'h0022; tx[2] = 16'h0033; spi(1'b0, 7'd8, 3);
    chk("R4 asc w0", lv(7'd8), 16'h0011);
    chk("R4 asc w1", lv(7'd9), 16'h0022);
    chk("R4 asc w2", lv(7'd10), 16'h0033);
    tx[0] = 0; tx[1] = 0; tx[2] = 0; spi(1'b1, 7'd8, 3);
    chk("R4 asc read", rx[2], 16'h0033);

    // R5 descending block with wrap
    wr1(7'd0, 16'h0000);
    tx[0] = 16'h0AAA; tx[1] = 16'h0BBB; tx[2] = 16'h0CCC; spi(1'b0, 7'd14, 3);
    chk("R5 desc w0", lv(7'd14), 16'h0AAA);
    chk("R5 desc w1", lv(7'd13), 16'h0BBB);
    chk("R5 desc w2", lv(7'd12), 16'h0CCC);
    tx[0] = 0; tx[1] = 0; tx[2] = 0; spi(1'b1, 7'd0, 3);
    chk("R5 wrap w0", rx[0], 16'h0000);
    chk("R5 wrap w1 reserved127", rx[1], 16'h0000);

    // R6 hold beats direction
    wr1(7'd0, 16'h0C00);
    tx[0] = 16'h7777; tx[1] = 16'h8888; spi(1'b0, 7'd22, 2);
    chk("R6 hold target", lv(7'd22), 16'h8888);
    chk("R6 hold neighbour", lv(7'd23), dflt(7'd23));

    // R8 R9 double buffering
    wr1(7'd0, 16'h0000);
    wr1(7'd1, 16'h0000);
    wr1(7'd16, 16'h0100);
    wr1(7'd4, 16'hBEEF);
    chk("R8 staged not live", lv(7'd4), dflt(7'd4));
    rd1(7'd4, r); chk("R9 written readback", r, 16'hBEEF);
    wr1(7'd0, 16'h0000);
    chk("R8 commit", lv(7'd4), 16'hBEEF);
    wr1(7'd1, 16'h2000);
    wr1(7'd6, 16'h1111);
    chk("R8 staged reg6", lv(7'd6), dflt(7'd6));
    wr1(7'd0, 16'h0000);
    chk("R8 commit reg6", lv(7'd6), 16'h1111);
    wr1(7'd6, 16'h2222);
    rd1(7'd6, r); chk("R9 live readback", r, 16'h1111);

    // R11 calibration pulse
    c0 = cal_hi;
    wr1(7'd0, 16'h0004);
    chk("R11 one cycle pulse", 16'(cal_hi - c0), 16'd1);
    c0 = cal_hi;
    wr1(7'd0, 16'h0000);
    chk("R11 no pulse", 16'(cal_hi - c0), 16'd0);

    // R10 soft reset
    wr1(7'd0, 16'h0002);
    ok = 1;
    for (int i = 0; i < NR; i++) if (live[i*16 +: 16] !== dflt(ADDRS[i])) ok = 0;
    chk("R10 all defaults", 16'(ok), 16'd1);
    rd1(7'd0, r); chk("R10 reg0 self-clear", r, dflt(7'd0));
    rd1(7'd6, r); chk("R10 staged cleared", r, dflt(7'd6));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule